// File: doc/BRIEF.md
# Guarded Watchdog Control Register

This block is the control register of a serial-slave supervisor device, seen one byte transaction at a time. A bus front end that has already decoded the bit-level signalling passes in three things: strobes for transaction begin and end, write data bytes on a valid/ready stream, and read requests. For every data byte the block returns an accept (ACK) or refuse (NACK) decision one cycle later. It holds a volatile write-enable latch, a second register-unlock latch, and two retained watchdog-select bits. It also drives a busy flag while a retained-bit update is in progress, and a decoded watchdog period selection.

The watchdog bits change only after a strict sequence. The first write, 02H, opens the write-enable latch. The second, 06H, arms the unlock latch. A third byte then carries the new watchdog bits. Every write commits only when its transaction ends with a stop strobe. A transaction holding more than one byte is aborted. A begin strobe with no stop before it throws away any byte still pending. Read requests return the register image and never disturb the sequence.

The write stream never applies back-pressure: `wr_ready` is held high, and a byte is taken in every cycle that `wr_valid` is high. If a begin or stop strobe arrives in the same cycle as a byte, the strobe takes priority and the byte is dropped with no decision. Stop outranks begin.

Top module: `ctrlreg_guard`

## Requirements
- R1: After reset the write-enable latch and the unlock latch are 0, `wd_sel` is 2'b11, `nv_busy` is 0, and a read returns 8'h30.
- R2: While the write-enable latch is 0, only the byte 8'h02 is ACKed. Every other byte is NACKed and changes nothing.
- R3: An ACKed 8'h02 sets the write-enable latch. An ACKed 8'h00, accepted only when the unlock latch is 0 and the write-enable latch is 1, clears it. Latch and watchdog state change only in the cycle of a stop strobe, and a volatile write never raises `nv_busy`.
- R4: With the write-enable latch at 1 and the unlock latch at 0, the byte 8'h06 is ACKed and sets the unlock latch.
- R5: With the unlock latch at 1, a byte with bits 7, 6, 3, 2 and 0 at zero and bit 1 at one is ACKed. At stop it loads bits 5:4 into `wd_sel`, clears the unlock latch, keeps the write-enable latch, and holds `nv_busy` high for exactly BUSY_CYCLES cycles starting the cycle after the stop.
- R6: With the unlock latch at 1, a byte with bits 7, 6, 3 and 0 at zero and bits 2 and 1 at one is ACKed and leaves `wd_sel` and both latches unchanged.
- R7: A second or later data byte in one transaction is NACKed, and that transaction commits nothing.
- R8: A read request gives `rd_valid` one cycle later with `rd_data` = {2'b00, wd_sel, 1'b0, unlock latch, write-enable latch, 1'b0}. Reads between unlock steps do not cancel the sequence.
- R9: While `nv_busy` is high, every byte is NACKed and the register does not change.
- R10: A begin strobe inside an open transaction discards the pending byte. A byte outside any transaction is NACKed.
- R11: Any byte matching no accepted pattern for the current latch state is NACKed and changes nothing. This includes 8'h00 while the unlock latch is 1.
- R12: `wd_period` is one-hot from `wd_sel`: 2'b00 gives 3'b100 (longest), 2'b01 gives 3'b010, 2'b10 gives 3'b001 (shortest), and 2'b11 (disabled) gives 3'b000.
- R13: `wr_ready` is always 1. `ack_valid` is high exactly one cycle after each byte taken outside a strobe cycle, with `ack_ok` = 1 for ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Transaction begin strobe |
| bus_stop | input | 1 | Transaction end strobe; commits the pending byte |
| wr_valid | input | 1 | Write data byte valid |
| wr_ready | output | 1 | Write data ready, always high |
| wr_data | input | 8 | Write data byte |
| ack_valid | output | 1 | Decision valid for the previous byte |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| rd_req | input | 1 | Read request strobe |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Register image |
| nv_busy | output | 1 | Retained-bit update in progress |
| wd_sel | output | 2 | Current watchdog select bits |
| wd_period | output | 3 | One-hot decoded watchdog period |

## Verification
The hardest state to reach from the ports is a byte that lands inside the busy window. It needs the full three-step unlock, a committed retained write, and then a new transaction within BUSY_CYCLES. The bench shortens BUSY_CYCLES to 40 and issues that transaction right after the committing stop. It also builds two-byte transactions and repeated begin strobes mid-sequence, interleaves reads between unlock steps, and follows each of these with a read to confirm that nothing committed.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_WEL,
    OP_CLR_WEL,
    OP_SET_RWEL,
    OP_NV_WRITE
  } op_e;

  localparam logic [7:0] BYTE_OPEN  = 8'h02;
  localparam logic [7:0] BYTE_ARM   = 8'h06;
  localparam logic [7:0] BYTE_CLOSE = 8'h00;
  localparam logic [7:0] FIX_MASK   = 8'hCF;
  localparam logic [1:0] WD_RESET   = 2'b11;

  function automatic logic [2:0] wd_decode(input logic [1:0] sel);
    logic [2:0] r;
    case (sel)
      2'b00:   r = 3'b100;
      2'b01:   r = 3'b010;
      2'b10:   r = 3'b001;
      default: r = 3'b000;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] reg_image(input logic [1:0] wd,
                                           input logic unl,
                                           input logic wen);
    return {2'b00, wd, 1'b0, unl, wen, 1'b0};
  endfunction

endpackage

// File: rtl/ctrlreg_txn.sv
module ctrlreg_txn (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic byte_i,
  output logic open_o,
  output logic first_o
);
  logic open_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (stop_i) begin
      open_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (start_i) begin
      open_q <= 1'b1;
      seen_q <= 1'b0;
    end else if (byte_i && open_q) begin
      seen_q <= 1'b1;
    end
  end

  assign open_o  = open_q;
  assign first_o = open_q & ~seen_q;
endmodule

// File: rtl/ctrlreg_decode.sv
module ctrlreg_decode import ctrlreg_pkg::*; (
  input  logic [7:0] data_i,
  input  logic       wen_i,
  input  logic       unl_i,
  output op_e        op_o
);
  logic [7:0] fixed_bits;
  assign fixed_bits = data_i & FIX_MASK;

  always_comb begin
    op_o = OP_NONE;
    if (unl_i) begin
      if (fixed_bits == BYTE_OPEN)     op_o = OP_NV_WRITE;
      else if (fixed_bits == BYTE_ARM) op_o = OP_SET_RWEL;
    end else begin
      if (data_i == BYTE_OPEN)                 op_o = OP_SET_WEL;
      else if (wen_i && data_i == BYTE_CLOSE)  op_o = OP_CLR_WEL;
      else if (wen_i && data_i == BYTE_ARM)    op_o = OP_SET_RWEL;
    end
  end
endmodule

// File: rtl/ctrlreg_nvtimer.sv
module ctrlreg_nvtimer #(
  parameter int BUSY_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ctrlreg_guard.sv
module ctrlreg_guard import ctrlreg_pkg::*; #(
  parameter int BUSY_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       ack_valid,
  output logic       ack_ok,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       nv_busy,
  output logic [1:0] wd_sel,
  output logic [2:0] wd_period
);
  logic       byte_evt, in_txn, first_slot, busy_w;
  logic       accept, apply, nv_load;
  op_e        op_now, pend_op_q;
  logic [1:0] pend_wd_q;
  logic       wel_q, rwel_q;
  logic [1:0] wd_q;

  assign wr_ready = 1'b1;
  assign byte_evt = wr_valid & ~bus_start & ~bus_stop;

  ctrlreg_txn u_txn (
    .clk(clk), .rst_n(rst_n), .start_i(bus_start), .stop_i(bus_stop),
    .byte_i(byte_evt), .open_o(in_txn), .first_o(first_slot)
  );

  ctrlreg_decode u_dec (
    .data_i(wr_data), .wen_i(wel_q), .unl_i(rwel_q), .op_o(op_now)
  );

  ctrlreg_nvtimer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(nv_load), .busy_o(busy_w)
  );

  assign accept  = byte_evt & first_slot & ~busy_w & (op_now != OP_NONE);
  assign apply   = bus_stop & in_txn & (pend_op_q != OP_NONE);
  assign nv_load = apply & (pend_op_q == OP_NV_WRITE);

  // Decision for each byte, one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
    end else begin
      ack_valid <= byte_evt;
      ack_ok    <= accept;
    end
  end

  // Pending operation, held until stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op_q <= OP_NONE;
      pend_wd_q <= 2'b00;
    end else if (bus_stop || bus_start) begin
      pend_op_q <= OP_NONE;
    end else if (byte_evt) begin
      pend_op_q <= accept ? op_now : OP_NONE;
      pend_wd_q <= wr_data[5:4];
    end
  end

  // Register state, changed only at a committing stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      wd_q   <= WD_RESET;
    end else if (apply) begin
      case (pend_op_q)
        OP_SET_WEL:  wel_q <= 1'b1;
        OP_CLR_WEL:  wel_q <= 1'b0;
        OP_SET_RWEL: begin
          wel_q  <= 1'b1;
          rwel_q <= 1'b1;
        end
        OP_NV_WRITE: begin
          wd_q   <= pend_wd_q;
          rwel_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // Read path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= reg_image(wd_q, rwel_q, wel_q);
    end
  end

  assign nv_busy   = busy_w;
  assign wd_sel    = wd_q;
  assign wd_period = wd_decode(wd_q);
endmodule

// File: rtl/ctrlreg_guard_chk.sv
module ctrlreg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_start,
  input logic       bus_stop,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic       ack_valid,
  input logic       ack_ok,
  input logic       nv_busy,
  input logic [1:0] wd_sel,
  input logic [2:0] wd_period,
  input logic       wel_q,
  input logic       rwel_q,
  input logic       in_txn,
  input logic       first_slot
);
  logic byte_evt;
  assign byte_evt = wr_valid & ~bus_start & ~bus_stop;

  a_r1_reset_defaults: assert property (@(posedge clk)
    !rst_n |=> (wd_sel == 2'b11 && !wel_q && !rwel_q && !nv_busy));

  a_r2_locked_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && !wel_q && wr_data != 8'h02) |=> (ack_valid && !ack_ok));

  a_r3_change_only_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_stop |=> ($stable(wel_q) && $stable(rwel_q) && $stable(wd_sel)));

  a_r4_unlock_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rwel_q |-> wel_q);

  a_r5_busy_starts_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_busy) |-> $past(bus_stop));

  a_r7_extra_byte_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && in_txn && !first_slot) |=> (ack_valid && !ack_ok));

  a_r9_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && nv_busy) |=> (ack_valid && !ack_ok));

  a_r10_outside_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && !in_txn) |=> (ack_valid && !ack_ok));

  a_r12_period_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wd_period) && ((wd_sel == 2'b11) == (wd_period == 3'b000)));
endmodule

bind ctrlreg_guard ctrlreg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .wr_valid(wr_valid), .wr_data(wr_data), .ack_valid(ack_valid),
  .ack_ok(ack_ok), .nv_busy(nv_busy), .wd_sel(wd_sel), .wd_period(wd_period),
  .wel_q(wel_q), .rwel_q(rwel_q), .in_txn(in_txn), .first_slot(first_slot)
);

// File: tb/ctrlreg_guard_tb.sv
`timescale 1ns/1ps
module ctrlreg_guard_tb;
  localparam int BUSY = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, ack_valid, ack_ok, rd_valid, nv_busy;
  logic [7:0] rd_data;
  logic [1:0] wd_sel;
  logic [2:0] wd_period;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_seen = 0;

  always #5 clk = ~clk;

  ctrlreg_guard #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .nv_busy(nv_busy),
    .wd_sel(wd_sel), .wd_period(wd_period)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_wel, m_rwel, m_open, m_ackv, m_ack, m_rdv;
  bit [1:0] m_wd;
  bit [7:0] m_rd;
  int       m_busy, m_nbytes, m_pend;

  function automatic int classify(input bit [7:0] d, input bit wel, input bit rwel);
    // 0 reject, 1 set wel, 2 clear wel, 3 arm, 4 retained write
    if (rwel) begin
      if ((d & 8'hCF) == 8'h02) return 4;
      if ((d & 8'hCF) == 8'h06) return 3;
      return 0;
    end
    if (d == 8'h02) return 1;
    if (wel && d == 8'h00) return 2;
    if (wel && d == 8'h06) return 3;
    return 0;
  endfunction

  function automatic bit [2:0] period_of(input bit [1:0] s);
    if (s == 2'b00) return 3'b100;
    if (s == 2'b01) return 3'b010;
    if (s == 2'b10) return 3'b001;
    return 3'b000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wel = 0; m_rwel = 0; m_wd = 2'b11; m_busy = 0; m_open = 0;
      m_nbytes = 0; m_pend = -1; m_ackv = 0; m_ack = 0; m_rdv = 0; m_rd = 0;
    end else begin
      automatic bit was_busy = (m_busy > 0);
      automatic bit loaded = 0;
      m_ackv = 0;
      m_rdv = rd_req;
      if (rd_req) m_rd = {2'b00, m_wd, 1'b0, m_rwel, m_wel, 1'b0};
      if (bus_stop) begin
        if (m_open && m_pend >= 0) begin
          case (classify(m_pend[7:0], m_wel, m_rwel))
            1: m_wel = 1;
            2: m_wel = 0;
            3: begin m_wel = 1; m_rwel = 1; end
            4: begin m_wd = m_pend[5:4]; m_rwel = 0; m_busy = BUSY; loaded = 1; end
            default: ;
          endcase
        end
        m_open = 0; m_pend = -1;
      end else if (bus_start) begin
        m_open = 1; m_nbytes = 0; m_pend = -1;
      end else if (wr_valid) begin
        m_ackv = 1; m_ack = 0;
        if (m_open) begin
          if (!was_busy && m_nbytes == 0 && classify(wr_data, m_wel, m_rwel) != 0) begin
            m_ack = 1; m_pend = wr_data;
          end else begin
            m_pend = -1;
          end
          m_nbytes++;
        end
      end
      if (!loaded && m_busy > 0) m_busy--;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(wr_ready == 1'b1, "R13", "wr_ready", wr_ready, 1);
      chk(ack_valid == m_ackv, "R13", "ack_valid", ack_valid, m_ackv);
      if (m_ackv) chk(ack_ok == m_ack, "R13", "ack_ok", ack_ok, m_ack);
      chk(nv_busy == (m_busy > 0), "R5", "nv_busy", nv_busy, m_busy > 0);
      chk(wd_sel == m_wd, "R5", "wd_sel", wd_sel, m_wd);
      chk(wd_period == period_of(m_wd), "R12", "wd_period", wd_period, period_of(m_wd));
      chk(rd_valid == m_rdv, "R8", "rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk(rd_data == m_rd, "R8", "rd_data", rd_data, m_rd);
      if (nv_busy) busy_seen++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_start();
    bus_start = 1; @(negedge clk); bus_start = 0;
  endtask

  task automatic do_stop();
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask

  task automatic do_byte(input logic [7:0] d, input bit exp, input string req);
    wr_valid = 1; wr_data = d; @(negedge clk); wr_valid = 0;
    chk(ack_valid && ack_ok == exp, req, "byte decision", ack_ok, exp);
  endtask

  task automatic wr1(input logic [7:0] d, input bit exp, input string req);
    do_start(); do_byte(d, exp, req); do_stop();
  endtask

  task automatic rd_expect(input logic [7:0] exp, input string req);
    rd_req = 1; @(negedge clk); rd_req = 0;
    chk(rd_valid && rd_data == exp, req, "register image", rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wd_sel == 2'b11 && !nv_busy, "R1", "reset wd/busy", {nv_busy, wd_sel}, 3);
    rd_expect(8'h30, "R1");

    // R2: locked
    wr1(8'h06, 0, "R2"); wr1(8'h00, 0, "R2");
    rd_expect(8'h30, "R2");
    // R3: volatile enable on and off
    wr1(8'h02, 1, "R3"); rd_expect(8'h32, "R3");
    chk(!nv_busy, "R3", "no busy after volatile write", nv_busy, 0);
    wr1(8'h00, 1, "R3"); rd_expect(8'h30, "R3");
    wr1(8'h02, 1, "R3");
    // R11: unmatched
    wr1(8'h44, 0, "R11"); rd_expect(8'h32, "R11");
    // R7: two bytes in one transaction
    do_start(); do_byte(8'h06, 1, "R7"); do_byte(8'h06, 0, "R7"); do_stop();
    rd_expect(8'h32, "R7");
    // R10: repeated begin discards, byte outside transaction
    do_start(); do_byte(8'h06, 1, "R10"); do_start(); do_stop();
    rd_expect(8'h32, "R10");
    do_byte(8'h06, 0, "R10"); rd_expect(8'h32, "R10");
    // R4: arm
    wr1(8'h06, 1, "R4"); rd_expect(8'h36, "R4");
    // R6: bit 2 set keeps state
    wr1(8'h06, 1, "R6"); wr1(8'h26, 1, "R6"); rd_expect(8'h36, "R6");
    // R11: clear byte refused while armed
    wr1(8'h00, 0, "R11"); rd_expect(8'h36, "R11");
    // R5 + R9: retained write and busy window
    busy_seen = 0;
    wr1(8'h12, 1, "R5");
    chk(nv_busy && wd_sel == 2'b01, "R5", "busy and wd", {nv_busy, wd_sel}, 3'b101);
    chk(wd_period == 3'b010, "R12", "period 01", wd_period, 3'b010);
    wr1(8'h06, 0, "R9");
    rd_expect(8'h12, "R9");
    while (nv_busy) @(negedge clk);
    chk(busy_seen == BUSY, "R5", "busy length", busy_seen, BUSY);
    // R8: reads between unlock steps, then write 00
    wr1(8'h06, 1, "R8"); rd_expect(8'h16, "R8");
    wr1(8'h02, 1, "R8"); rd_expect(8'h02, "R8");
    chk(wd_period == 3'b100, "R12", "period 00", wd_period, 3'b100);
    while (nv_busy) @(negedge clk);
    wr1(8'h06, 1, "R12"); wr1(8'h22, 1, "R12");
    chk(wd_period == 3'b001, "R12", "period 10", wd_period, 3'b001);
    while (nv_busy) @(negedge clk);
    wr1(8'h06, 1, "R12"); wr1(8'h32, 1, "R12");
    chk(wd_period == 3'b000 && wd_sel == 2'b11, "R12", "disabled", wd_period, 0);
    while (nv_busy) @(negedge clk);
    // 02,06,02 sequence clears watchdog bits
    wr1(8'h02, 1, "R5"); wr1(8'h06, 1, "R5"); wr1(8'h02, 1, "R5");
    rd_expect(8'h02, "R5");
    repeat (BUSY + 2) @(negedge clk);
    // 02,06,06 keeps them and stays armed
    wr1(8'h02, 1, "R6"); wr1(8'h06, 1, "R6"); wr1(8'h06, 1, "R6");
    rd_expect(8'h06, "R6");
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule